// File: doc/BRIEF.md
# Reset Source Controller with Cause Logging

The block gathers nine active-low reset requests: the external power-on pin, a CPU lockup or system-reset request, a security-unit reset, a user reset qualified as cold, two watchdog timeouts, a JTAG high-Z reset, a JTAG software reset and a temperature-sensor reset. Each request passes through a two-flop synchroniser. The two watchdog requests can each be blocked by a 4-bit keyed field in the control register. Any request that is not blocked drives a stretched chip reset. The same request sets its bit in a sticky cause word, which software reads to learn why the chip last reset and clears by writing ones.

Software can pulse a reset of core 0 alone or of its debug logic alone. A power-gating-done event also pulses the debug reset unless a control bit suppresses it. The two boot-mode pins are captured when the power-on request releases. A bank of general-purpose words survives every reset except power-on, so they can hold wake-up entry points and arguments. All of this sits behind a flat 32-bit register port with a one-cycle write and a combinational read.

Top module: `rst_src_ctrl`

## Requirements
- R1: Each request input passes through two synchroniser flops. A level driven low just after edge k first affects the cause word and the chip reset at edge k+3.
- R2: The key at control bits 10:7 gates watchdog A (cause bit 4) and the key at control bits 31:28 gates watchdog B (cause bit 7). A key of 0x5 stops that watchdog from resetting the chip and from being logged. Any other key value, including 0x3 and 0xA, lets it through.
- R3: The cause word at 0x08 has one sticky bit per source: bit 0 power-on, 1 lockup/system request, 2 security unit, 3 cold user reset, 4 watchdog A, 5 JTAG high-Z, 6 JTAG software, 7 watchdog B, 8 thermal. Writing 1 to a bit clears it. A source active in the same cycle wins over the clear. Sources active together all set their bits.
- R4: While the power-on request is active, the cause word is forced to 0x001, the control register and the general-purpose words are cleared, and control and general-purpose writes are ignored.
- R5: `chip_rst` rises at the edge that first sees an active unblocked source. It stays high until 16 cycles after the last edge that saw one.
- R6: Writing 1 to control bit 13 pulses `core_rst` for 4 cycles, starting at the write edge. Bit 13 reads 1 while the pulse runs. Writing 0 has no effect. `core_rst` is also high whenever `chip_rst` is high.
- R7: Writing 1 to control bit 17 pulses `core_dbg_rst` for 4 cycles in the same way, and bit 17 reads 1 while the pulse runs. `core_dbg_rst` is also high whenever `chip_rst` is high.
- R8: A `pg_done` pulse starts the 4-cycle debug reset pulse when control bit 25 is 0. It is ignored when bit 25 is 1.
- R9: Register 0x1C returns in bits 25:24 the `boot_pins` value sampled at the edge where the synchronised power-on request releases. All its other bits read 0, and the value does not follow later pin changes. Register 0x04 returns `boot_cfg`.
- R10: Words at 0x20–0x3C and at 0x44 are read-write and reset to zero. 0x40 reads zero and ignores writes. Unmapped or misaligned addresses read zero.
- R11: The control register reads back only bits 10:7, 13, 17, 25 and 31:28. All other bits read 0.
- R12: A synchronous high `rst` clears all state and holds every output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset of all state |
| req_n | input | 9 | Active-low reset requests, indexed as the cause bits |
| boot_pins | input | 2 | Boot-mode pins, captured at power-on release |
| boot_cfg | input | 32 | Boot configuration word shown at 0x04 |
| pg_done | input | 1 | Power-gating-done event, one-cycle pulse |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 7 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr, combinational |
| chip_rst | output | 1 | Stretched chip reset |
| core_rst | output | 1 | Core 0 reset |
| core_dbg_rst | output | 1 | Core 0 debug reset |

## Verification
The sources are exercised one at a time, in simultaneous pairs, and together with power-on. This separates per-bit logging, the multi-set rule and power-on precedence. Each watchdog runs with key 0x5, with a non-pattern key and with 0xA, so that only the exact block key suppresses it. Software pulses and power-gating events are issued with the suppress bit both clear and set. A behavioural model predicts all three reset outputs on every clock, which pins down synchroniser latency and stretch length to the cycle.

// File: rtl/rsc_pkg.sv
package rsc_pkg;
    localparam int NUM_SRC      = 9;
    localparam int DW           = 32;
    localparam int AW           = 7;
    localparam int STRETCH_CYC  = 16;
    localparam int SW_PULSE_CYC = 4;
    localparam int GP_COUNT     = 10;
    localparam int GP_RO_IDX    = 8;
    localparam int GP_IW        = $clog2(GP_COUNT);

    // cause bit positions, one per request source
    localparam int SRC_POWER_ON  = 0;
    localparam int SRC_LOCKUP    = 1;
    localparam int SRC_SECURITY  = 2;
    localparam int SRC_USER_COLD = 3;
    localparam int SRC_WDOG_A    = 4;
    localparam int SRC_JTAG_HIZ  = 5;
    localparam int SRC_JTAG_SW   = 6;
    localparam int SRC_WDOG_B    = 7;
    localparam int SRC_THERMAL   = 8;

    localparam logic [AW-1:0] ADDR_CTRL     = 7'h00;
    localparam logic [AW-1:0] ADDR_BOOTCFG  = 7'h04;
    localparam logic [AW-1:0] ADDR_CAUSE    = 7'h08;
    localparam logic [AW-1:0] ADDR_BOOTMODE = 7'h1C;
    localparam logic [AW-1:0] ADDR_GP_FIRST = 7'h20;
    localparam logic [AW-1:0] ADDR_GP_LAST  = 7'h44;

    localparam int CTRL_WDA_LSB    = 7;
    localparam int CTRL_CORE_BIT   = 13;
    localparam int CTRL_DBG_BIT    = 17;
    localparam int CTRL_PGHOLD_BIT = 25;
    localparam int CTRL_WDB_LSB    = 28;
    localparam int BMODE_LSB       = 24;

    localparam logic [3:0] WDOG_BLOCK_KEY = 4'h5;

    typedef struct packed {
        logic [3:0] wdog_b_key;
        logic       pg_dbg_hold;
        logic [3:0] wdog_a_key;
    } ctrl_t;

    typedef enum logic [2:0] {
        RD_CTRL, RD_BOOTCFG, RD_CAUSE, RD_BOOTMODE, RD_GP, RD_NONE
    } rd_sel_e;

    function automatic logic wdog_blocked(input logic [3:0] key);
        return key == WDOG_BLOCK_KEY;
    endfunction

    function automatic logic [DW-1:0] ctrl_word(input ctrl_t c, input logic core_busy,
                                                input logic dbg_busy);
        logic [DW-1:0] w;
        w = '0;
        w[CTRL_WDA_LSB +: 4]  = c.wdog_a_key;
        w[CTRL_WDB_LSB +: 4]  = c.wdog_b_key;
        w[CTRL_PGHOLD_BIT]    = c.pg_dbg_hold;
        w[CTRL_CORE_BIT]      = core_busy;
        w[CTRL_DBG_BIT]       = dbg_busy;
        return w;
    endfunction

    function automatic rd_sel_e decode_addr(input logic [AW-1:0] a);
        if (a == ADDR_CTRL)     return RD_CTRL;
        if (a == ADDR_BOOTCFG)  return RD_BOOTCFG;
        if (a == ADDR_CAUSE)    return RD_CAUSE;
        if (a == ADDR_BOOTMODE) return RD_BOOTMODE;
        if (a[1:0] == 2'b00 && a >= ADDR_GP_FIRST && a <= ADDR_GP_LAST) return RD_GP;
        return RD_NONE;
    endfunction
endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] req_n_i,
    output logic [W-1:0] act_o
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                stage1_q[i] <= 1'b1;
                stage2_q[i] <= 1'b1;
            end else begin
                stage1_q[i] <= req_n_i[i];
                stage2_q[i] <= stage1_q[i];
            end
        end
    end

    assign act_o = ~stage2_q;

    // R1: a synchronised request needs the input low two edges earlier
    p_two_stage_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(stage2_q[0]) |-> $past(!stage1_q[0]));
endmodule

// File: rtl/rsc_pulse.sv
module rsc_pulse #(
    parameter int LEN = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic load_i,
    output logic busy_o
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load_i)        cnt_q <= CW'(LEN);
        else if (cnt_q != '0)   cnt_q <= cnt_q - CW'(1);
    end

    assign busy_o = (cnt_q != '0);

    // R5: a load is always followed by an asserted pulse
    p_load_busy_r5: assert property (@(posedge clk) disable iff (rst)
        load_i |=> busy_o);
endmodule

// File: rtl/rsc_cause.sv
module rsc_cause
    import rsc_pkg::*;
#(
    parameter int N = NUM_SRC
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] act_i,
    input  logic [3:0]   wdog_a_key_i,
    input  logic [3:0]   wdog_b_key_i,
    input  logic         clr_we_i,
    input  logic [N-1:0] clr_bits_i,
    output logic [N-1:0] cause_o,
    output logic         any_o
);
    logic [N-1:0] eff;
    logic [N-1:0] clr_mask;
    logic [N-1:0] cause_q;

    always_comb begin
        eff = act_i;
        if (wdog_blocked(wdog_a_key_i)) eff[SRC_WDOG_A] = 1'b0;
        if (wdog_blocked(wdog_b_key_i)) eff[SRC_WDOG_B] = 1'b0;
    end

    assign clr_mask = clr_we_i ? clr_bits_i : '0;
    assign any_o    = |eff;

    always_ff @(posedge clk) begin
        if (rst)                        cause_q <= '0;
        else if (act_i[SRC_POWER_ON])   cause_q <= {{(N-1){1'b0}}, 1'b1};
        else                            cause_q <= (cause_q & ~clr_mask) | eff;
    end

    assign cause_o = cause_q;

    // R4: power-on leaves only its own bit
    p_por_only_r4: assert property (@(posedge clk) disable iff (rst)
        act_i[SRC_POWER_ON] |=> (cause_o == {{(N-1){1'b0}}, 1'b1}));
    // R3: without clear or power-on no bit is lost
    p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
        (!act_i[SRC_POWER_ON] && !clr_we_i) |=> ((cause_o & $past(cause_o)) == $past(cause_o)));
    // R2: a blocked watchdog never changes its cause bit
    p_wdog_block_r2: assert property (@(posedge clk) disable iff (rst)
        (!act_i[SRC_POWER_ON] && act_i[SRC_WDOG_A] && wdog_blocked(wdog_a_key_i)
         && !(clr_we_i && clr_bits_i[SRC_WDOG_A]))
        |=> (cause_o[SRC_WDOG_A] == $past(cause_o[SRC_WDOG_A])));
endmodule

// File: rtl/rsc_gpr.sv
module rsc_gpr #(
    parameter int N_REG  = 10,
    parameter int RO_IDX = 8,
    parameter int DW     = 32,
    parameter int IW     = $clog2(N_REG)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr_i,
    input  logic          we_i,
    input  logic [IW-1:0] idx_i,
    input  logic [DW-1:0] wdata_i,
    output logic [DW-1:0] rdata_o
);
    logic [DW-1:0] bank [N_REG];

    for (genvar i = 0; i < N_REG; i++) begin : g_word
        if (i == RO_IDX) begin : g_ro
            assign bank[i] = '0;
        end else begin : g_rw
            always_ff @(posedge clk) begin
                if (rst || clr_i)                   bank[i] <= '0;
                else if (we_i && idx_i == IW'(i))   bank[i] <= wdata_i;
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < N_REG; i++) begin
            if (idx_i == IW'(i)) rdata_o = bank[i];
        end
    end
endmodule

// File: rtl/rst_src_ctrl.sv
module rst_src_ctrl
    import rsc_pkg::*;
#(
    parameter int STRETCH  = STRETCH_CYC,
    parameter int SW_PULSE = SW_PULSE_CYC
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_SRC-1:0]  req_n,
    input  logic [1:0]          boot_pins,
    input  logic [DW-1:0]       boot_cfg,
    input  logic                pg_done,
    input  logic                reg_we,
    input  logic [AW-1:0]       reg_addr,
    input  logic [DW-1:0]       reg_wdata,
    output logic [DW-1:0]       reg_rdata,
    output logic                chip_rst,
    output logic                core_rst,
    output logic                core_dbg_rst
);
    localparam int QW = $clog2(STRETCH + 1);

    logic [NUM_SRC-1:0] act;
    logic [NUM_SRC-1:0] cause;
    logic               any_act;
    logic               por_act;
    logic               por_q;
    logic [1:0]         bmode_q;
    ctrl_t              ctrl_q;
    rd_sel_e            sel;
    logic               ctrl_wr;
    logic               core_start;
    logic               dbg_start;
    logic               core_busy;
    logic               dbg_busy;
    logic [AW-1:0]      gp_off;
    logic [GP_IW-1:0]   gp_idx;
    logic [DW-1:0]      gp_rdata;
    logic               gp_we;

    rsc_sync #(.W(NUM_SRC)) u_sync (
        .clk(clk), .rst(rst), .req_n_i(req_n), .act_o(act)
    );

    assign por_act = act[SRC_POWER_ON];
    assign sel     = decode_addr(reg_addr);
    assign ctrl_wr = reg_we && (sel == RD_CTRL) && !por_act;
    assign gp_we   = reg_we && (sel == RD_GP) && !por_act;
    assign gp_off  = reg_addr - ADDR_GP_FIRST;
    assign gp_idx  = GP_IW'(gp_off >> 2);

    rsc_cause #(.N(NUM_SRC)) u_cause (
        .clk(clk), .rst(rst), .act_i(act),
        .wdog_a_key_i(ctrl_q.wdog_a_key), .wdog_b_key_i(ctrl_q.wdog_b_key),
        .clr_we_i(reg_we && (sel == RD_CAUSE)), .clr_bits_i(reg_wdata[NUM_SRC-1:0]),
        .cause_o(cause), .any_o(any_act)
    );

    always_ff @(posedge clk) begin
        if (rst || por_act) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q.wdog_a_key  <= reg_wdata[CTRL_WDA_LSB +: 4];
            ctrl_q.wdog_b_key  <= reg_wdata[CTRL_WDB_LSB +: 4];
            ctrl_q.pg_dbg_hold <= reg_wdata[CTRL_PGHOLD_BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            por_q   <= 1'b0;
            bmode_q <= '0;
        end else begin
            por_q <= por_act;
            if (por_q && !por_act) bmode_q <= boot_pins;
        end
    end

    assign core_start = ctrl_wr && reg_wdata[CTRL_CORE_BIT];
    assign dbg_start  = (ctrl_wr && reg_wdata[CTRL_DBG_BIT]) || (pg_done && !ctrl_q.pg_dbg_hold);

    rsc_pulse #(.LEN(STRETCH)) u_chip_pulse (
        .clk(clk), .rst(rst), .load_i(any_act), .busy_o(chip_rst)
    );
    rsc_pulse #(.LEN(SW_PULSE)) u_core_pulse (
        .clk(clk), .rst(rst), .load_i(core_start), .busy_o(core_busy)
    );
    rsc_pulse #(.LEN(SW_PULSE)) u_dbg_pulse (
        .clk(clk), .rst(rst), .load_i(dbg_start), .busy_o(dbg_busy)
    );

    assign core_rst     = chip_rst || core_busy;
    assign core_dbg_rst = chip_rst || dbg_busy;

    rsc_gpr #(.N_REG(GP_COUNT), .RO_IDX(GP_RO_IDX), .DW(DW), .IW(GP_IW)) u_gpr (
        .clk(clk), .rst(rst), .clr_i(por_act), .we_i(gp_we), .idx_i(gp_idx),
        .wdata_i(reg_wdata), .rdata_o(gp_rdata)
    );

    always_comb begin
        unique case (sel)
            RD_CTRL:     reg_rdata = ctrl_word(ctrl_q, core_busy, dbg_busy);
            RD_BOOTCFG:  reg_rdata = boot_cfg;
            RD_CAUSE:    reg_rdata = {{(DW-NUM_SRC){1'b0}}, cause};
            RD_BOOTMODE: reg_rdata = {{(DW-BMODE_LSB-2){1'b0}}, bmode_q, {BMODE_LSB{1'b0}}};
            RD_GP:       reg_rdata = gp_rdata;
            default:     reg_rdata = '0;
        endcase
    end

    // cycles since the last edge that saw an active source (saturating)
    logic [QW-1:0] quiet_q;
    always_ff @(posedge clk) begin
        if (rst || any_act)              quiet_q <= '0;
        else if (quiet_q != QW'(STRETCH)) quiet_q <= quiet_q + QW'(1);
    end

    // R5: the chip reset only drops after the full stretch window
    p_stretch_len_r5: assert property (@(posedge clk) disable iff (rst)
        $fell(chip_rst) |-> (quiet_q == QW'(STRETCH)));
    // R6 / R7: core resets follow the chip reset
    p_core_follow_r6: assert property (@(posedge clk) disable iff (rst)
        chip_rst |-> (core_rst && core_dbg_rst));
    // R8: a suppressed power-gating event raises no debug reset
    p_pg_hold_r8: assert property (@(posedge clk) disable iff (rst)
        (pg_done && ctrl_q.pg_dbg_hold && !dbg_busy && !ctrl_wr && !any_act && !chip_rst)
        |=> !core_dbg_rst);
    // R9: the boot mode only moves at power-on release
    p_bmode_hold_r9: assert property (@(posedge clk) disable iff (rst)
        !(por_q && !por_act) |=> $stable(bmode_q));
endmodule

// File: tb/rst_src_ctrl_tb_top.sv
module rst_src_ctrl_tb_top;
    import rsc_pkg::*;

    logic        clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst = 1'b1;
    logic [8:0]  req_n = '1;
    logic [1:0]  boot_pins = 2'b00;
    logic [31:0] boot_cfg = 32'h1234_5678;
    logic        pg_done = 1'b0;
    logic        reg_we = 1'b0;
    logic [6:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        chip_rst, core_rst, core_dbg_rst;

    rst_src_ctrl dut_i (
        .clk(clk), .rst(rst), .req_n(req_n), .boot_pins(boot_pins), .boot_cfg(boot_cfg),
        .pg_done(pg_done), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .chip_rst(chip_rst), .core_rst(core_rst),
        .core_dbg_rst(core_dbg_rst)
    );

    int checks = 0;
    int failures = 0;
    bit done = 0;

    task automatic chk(input string tag, input logic [31:0] actual, input logic [31:0] expected);
        checks++;
        if (actual !== expected) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
        end
    endtask

    // ---------------- reference model ----------------
    logic [8:0]  m_h1 = '1, m_h2 = '1, m_act = '0, m_eff = '0, m_cause = '0;
    logic [3:0]  m_ka = '0, m_kb = '0;
    logic        m_hold = 0, m_por_prev = 0;
    int          m_chip = 0, m_core = 0, m_dbg = 0;
    logic [1:0]  m_bmode = '0;
    logic [31:0] m_gp [10];
    logic        s_rst, s_we, s_pg, ctrl_ok, cstart, dstart;
    logic [8:0]  s_req;
    logic [6:0]  s_addr;
    logic [31:0] s_wd;
    logic [1:0]  s_boot;

    initial for (int i = 0; i < 10; i++) m_gp[i] = '0;

    function automatic logic is_gp(input logic [6:0] a);
        return (a[1:0] == 2'b00) && (a >= 7'h20) && (a <= 7'h44);
    endfunction

    function automatic logic [31:0] model_rd(input logic [6:0] a);
        logic [31:0] v;
        v = '0;
        if (a == 7'h00) begin
            v[10:7] = m_ka; v[31:28] = m_kb; v[25] = m_hold;
            v[13] = (m_core != 0); v[17] = (m_dbg != 0);
        end else if (a == 7'h04) v = boot_cfg;
        else if (a == 7'h08) v = {23'd0, m_cause};
        else if (a == 7'h1C) v = {6'd0, m_bmode, 24'd0};
        else if (is_gp(a)) v = m_gp[(int'(a) - 32) / 4];
        return v;
    endfunction

    always @(posedge clk) begin
        s_rst = rst; s_req = req_n; s_we = reg_we; s_addr = reg_addr;
        s_wd = reg_wdata; s_pg = pg_done; s_boot = boot_pins;
        #1;
        if (s_rst) begin
            m_h1 = '1; m_h2 = '1; m_cause = '0; m_ka = '0; m_kb = '0; m_hold = 0;
            m_por_prev = 0; m_chip = 0; m_core = 0; m_dbg = 0; m_bmode = '0;
            for (int i = 0; i < 10; i++) m_gp[i] = '0;
        end else begin
            m_act = ~m_h2;
            m_eff = m_act;
            if (m_ka == 4'h5) m_eff[4] = 1'b0;
            if (m_kb == 4'h5) m_eff[7] = 1'b0;
            ctrl_ok = s_we && (s_addr == 7'h00) && !m_act[0];
            cstart  = ctrl_ok && s_wd[13];
            dstart  = (ctrl_ok && s_wd[17]) || (s_pg && !m_hold);
            if (m_act[0]) m_cause = 9'h001;
            else m_cause = (m_cause & ~((s_we && s_addr == 7'h08) ? s_wd[8:0] : 9'h0)) | m_eff;
            if (m_por_prev && !m_act[0]) m_bmode = s_boot;
            m_por_prev = m_act[0];
            if (m_act[0]) begin
                m_ka = '0; m_kb = '0; m_hold = 0;
                for (int i = 0; i < 10; i++) m_gp[i] = '0;
            end else begin
                if (ctrl_ok) begin m_ka = s_wd[10:7]; m_kb = s_wd[31:28]; m_hold = s_wd[25]; end
                if (s_we && is_gp(s_addr) && s_addr != 7'h40) m_gp[(int'(s_addr) - 32) / 4] = s_wd;
            end
            m_chip = (|m_eff) ? 16 : ((m_chip > 0) ? m_chip - 1 : 0);
            m_core = cstart ? 4 : ((m_core > 0) ? m_core - 1 : 0);
            m_dbg  = dstart ? 4 : ((m_dbg > 0) ? m_dbg - 1 : 0);
            m_h2 = m_h1; m_h1 = s_req;
        end
        if (!done) begin
            chk("R5 chip_rst", {31'd0, chip_rst}, {31'd0, m_chip != 0});
            chk("R6 core_rst", {31'd0, core_rst}, {31'd0, (m_chip != 0) || (m_core != 0)});
            chk("R7/R8 core_dbg_rst", {31'd0, core_dbg_rst}, {31'd0, (m_chip != 0) || (m_dbg != 0)});
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [6:0] a, input string tag);
        reg_addr = a;
        #1;
        chk(tag, reg_rdata, model_rd(a));
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_src(input logic [8:0] m, input int n);
        req_n = req_n & ~m;
        idle(n);
        req_n = req_n | m;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        // R12 reset state
        chk("R12 chip_rst after reset", {31'd0, chip_rst}, 32'd0);
        rd(7'h08, "R12 cause after reset");
        rd(7'h00, "R12 ctrl after reset");

        // R4 / R9 power-on with a control write during it
        boot_pins = 2'b10;
        req_n[0] = 1'b0;
        idle(3);
        wr(7'h00, 32'h5000_0280);
        idle(2);
        req_n[0] = 1'b1;
        idle(20);
        boot_pins = 2'b01;
        idle(2);
        rd(7'h08, "R4 cause after power-on");
        rd(7'h00, "R4 ctrl write ignored during power-on");
        rd(7'h1C, "R9 boot mode captured");
        chk("R9 boot mode value", {30'd0, reg_rdata[25:24]}, 32'd2);
        rd(7'h04, "R9 boot cfg");

        // R3 write-1-to-clear
        wr(7'h08, 32'h1);
        rd(7'h08, "R3 clear power-on bit");

        // R2 watchdog A unmasked with key 0
        pulse_src(9'h010, 3);
        idle(20);
        rd(7'h08, "R2 watchdog A logged");
        wr(7'h08, 32'h1FF);

        // R2 watchdog A blocked by 0x5
        wr(7'h00, 32'h0000_0280);
        rd(7'h00, "R11 ctrl readback keys");
        pulse_src(9'h010, 3);
        idle(20);
        rd(7'h08, "R2 watchdog A blocked");

        // R2 key 0x3 passes A, key 0x5 blocks B
        wr(7'h00, 32'h5000_0180);
        pulse_src(9'h090, 3);
        idle(20);
        rd(7'h08, "R2 A passes with 0x3, B blocked");
        wr(7'h08, 32'h1FF);

        // R2 watchdog B with 0xA
        wr(7'h00, 32'hA000_0000);
        pulse_src(9'h080, 3);
        idle(20);
        rd(7'h08, "R2 watchdog B passes with 0xA");
        wr(7'h08, 32'h1FF);

        // R3 simultaneous sources
        pulse_src(9'h102, 2);
        idle(20);
        rd(7'h08, "R3 simultaneous lockup and thermal");
        chk("R3 both bits", reg_rdata, 32'h0000_0102);
        wr(7'h08, 32'h1FF);

        // R6 core software reset
        wr(7'h00, 32'h0000_2000);
        rd(7'h00, "R6 core bit reads 1 during pulse");
        idle(6);
        rd(7'h00, "R6 core bit self-cleared");
        wr(7'h00, 32'h0000_0000);

        // R7 debug software reset
        wr(7'h00, 32'h0002_0000);
        rd(7'h00, "R7 debug bit reads 1 during pulse");
        idle(6);

        // R8 power-gating event, not suppressed then suppressed
        pg_done = 1'b1; idle(1); pg_done = 1'b0;
        chk("R8 pg event raises debug reset", {31'd0, core_dbg_rst}, 32'd1);
        idle(6);
        wr(7'h00, 32'h0200_0000);
        pg_done = 1'b1; idle(1); pg_done = 1'b0;
        chk("R8 pg event suppressed", {31'd0, core_dbg_rst}, 32'd0);
        idle(4);
        rd(7'h00, "R11 ctrl hold bit readback");

        // R10 general-purpose words
        for (int i = 0; i < 10; i++) wr(7'(32 + 4 * i), 32'hA500_0000 + 32'(i * 32'h111));
        for (int i = 0; i < 10; i++) rd(7'(32 + 4 * i), "R10 gp readback");
        rd(7'h40, "R10 read-only word");
        chk("R10 0x40 is zero", reg_rdata, 32'd0);
        rd(7'h0C, "R10 unmapped");
        rd(7'h21, "R10 misaligned");

        // R1 synchroniser latency
        req_n[6] = 1'b0;
        idle(1);
        chk("R1 no effect after one edge", {31'd0, chip_rst}, 32'd0);
        idle(1);
        chk("R1 no effect after two edges", {31'd0, chip_rst}, 32'd0);
        idle(1);
        chk("R1 chip reset after three edges", {31'd0, chip_rst}, 32'd1);
        req_n[6] = 1'b1;
        idle(22);
        rd(7'h08, "R1 JTAG software bit");
        wr(7'h08, 32'h1FF);

        // R4 power-on together with another source clears gp and cause
        pulse_src(9'h021, 4);
        idle(22);
        rd(7'h08, "R4 power-on dominates");
        rd(7'h20, "R4 gp cleared by power-on");

        idle(2);
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule